// File: doc/BRIEF.md
# Global Counter with Auto-Increment Comparator

This block keeps a 64-bit free-running count of clock cycles and compares it against one 64-bit compare value. Software reaches it through a simple 32-bit register bus: one write strobe with address and data, and a read data bus that follows the address combinationally. The counter is shown as two 32-bit halves. Software can load each half directly and starts or stops counting through a control bit. Because the counter never stalls for a read, software gets a consistent 64-bit time by reading the high half, then the low half, then the high half again, and retrying if the two high values differ.

When the comparator is enabled and the count equals the compare value, a sticky pending flag sets. The interrupt output is that flag gated by an enable bit. With auto-increment on, every match adds a programmable increment to the compare value, so the block produces periodic events without software help. Every write to a compare, increment, control or counter register sets its own sticky acknowledge bit. Software clears an acknowledge bit by writing 1 to it.

Top module: `gtimer_cmp`

## Requirements
- R1: After reset the counter, the compare value, the increment, the control bits, the interrupt enable, the pending flag and all acknowledge bits are zero, and `irq` is low.
- R2: While control bit 8 (run) is set, the counter rises by exactly 1 on every clock with a carry from the low half into the high half. While run is clear it holds its value.
- R3: Offset 0x100 reads the low 32 bits of the counter and 0x104 reads the high 32 bits. A write to either offset loads that half with the write data and leaves the other half unchanged.
- R4: With control bit 0 (compare enable) set, a cycle in which the counter equals the compare value {0x204, 0x200} sets the pending flag, which reads as bit 0 of offset 0x244 from the next cycle.
- R5: `irq` is high exactly when the pending flag and bit 0 of the enable register at 0x248 are both set. Clearing the enable bit hides the interrupt but keeps the flag.
- R6: Writing 1 to bit 0 of 0x244 clears the pending flag. Writing 0 there leaves it set.
- R7: With control bit 1 (auto-increment) set, every match adds the 32-bit increment at 0x208 to the full 64-bit compare value, with carry into the high half. Without it, the compare value stays as written.
- R8: Writes to 0x200, 0x204, 0x208 and 0x240 set bits 0, 1, 2 and 16 of the acknowledge register at 0x24C. Each of these bits stays set until 1 is written to that bit position.
- R9: Writes to 0x100 and 0x104 set bits 0 and 1 of the acknowledge register at 0x110. Each of these bits stays set until 1 is written to that bit position.
- R10: The control register keeps only bits 8, 1 and 0 and reads 0 in every other bit. Addresses outside the map read as 0, and a write to them changes no register.
- R11: With compare enable clear, the counter passing the compare value never sets the pending flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 12 | Byte offset of the register |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data for `bus_addr`, combinational |
| irq | output | 1 | Level interrupt: pending flag AND enable |

## Verification
The bench targets carries at the 32-bit seam. It loads the counter near the top of its low half and lets it run across the boundary, and it lets auto-increment push the compare value across the same boundary. A design that dropped either carry would read back a stale high half. It counts exact cycles between start and stop and predicts the compare value after several periodic matches, so a counter that skipped or doubled a tick, or a comparator that added the increment twice or never, gives the wrong number. It checks acknowledge bits one at a time while their neighbours stay set, which catches a clear that wipes the whole register. It also checks that the enable masks only the output and not the pending flag, that writing 0 to the status register leaves the flag set, and that writes to unmapped offsets reach no register.

// File: rtl/gtc_pkg.sv
// Package gtc_pkg
// Shared register offsets and bit positions for the global counter block.
// Assumes a 12-bit byte-offset register space with 32-bit registers.
package gtc_pkg;
    localparam int unsigned OFF_W = 12;

    localparam logic [OFF_W-1:0] OFF_CNT_LO  = 12'h100;
    localparam logic [OFF_W-1:0] OFF_CNT_HI  = 12'h104;
    localparam logic [OFF_W-1:0] OFF_CNT_ACK = 12'h110;
    localparam logic [OFF_W-1:0] OFF_CMP_LO  = 12'h200;
    localparam logic [OFF_W-1:0] OFF_CMP_HI  = 12'h204;
    localparam logic [OFF_W-1:0] OFF_CMP_INC = 12'h208;
    localparam logic [OFF_W-1:0] OFF_CTRL    = 12'h240;
    localparam logic [OFF_W-1:0] OFF_PEND    = 12'h244;
    localparam logic [OFF_W-1:0] OFF_IEN     = 12'h248;
    localparam logic [OFF_W-1:0] OFF_ACK     = 12'h24C;

    localparam int unsigned CTRL_RUN_BIT  = 8;
    localparam int unsigned CTRL_AUTO_BIT = 1;
    localparam int unsigned CTRL_EN_BIT   = 0;

    localparam int unsigned ACK_CMPLO_BIT = 0;
    localparam int unsigned ACK_CMPHI_BIT = 1;
    localparam int unsigned ACK_INC_BIT   = 2;
    localparam int unsigned ACK_CTRL_BIT  = 16;

    localparam int unsigned CNT_ACK_N = 2;
    localparam int unsigned GBL_ACK_N = 4;

    typedef struct packed {
        logic run;
        logic auto_inc;
        logic cmp_en;
    } ctrl_t;
endpackage

// File: rtl/gtc_stickybits.sv
// Module gtc_stickybits
// A row of N sticky flags. Each flag sets on its set pulse and clears when
// its clear pulse is high. If both arrive in the same cycle, set wins so
// that no event is lost. Assumes set and clear are single-cycle qualified.
module gtc_stickybits #(
    parameter int unsigned N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flags_o
);
    for (genvar gi = 0; gi < N; gi++) begin : g_bit
        // Hold one flag: set has priority over the write-1 clear.
        always_ff @(posedge clk) begin
            if (!rst_n)
                flags_o[gi] <= 1'b0;
            else if (set_i[gi])
                flags_o[gi] <= 1'b1;
            else if (clr_i[gi])
                flags_o[gi] <= 1'b0;
        end

        p_set_lands_r8: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[gi] |=> flags_o[gi]);
        p_sticky_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (flags_o[gi] && !clr_i[gi]) |=> flags_o[gi]);
        p_clear_drops_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[gi] && !set_i[gi]) |=> !flags_o[gi]);
    end
endmodule

// File: rtl/gtc_counter.sv
// Module gtc_counter
// Free-running counter of 2*HW bits built from two HW-bit halves. A load
// of either half replaces that half and skips the increment for that
// cycle. Otherwise the counter steps by one while run is high. Assumes at
// most one half is loaded per cycle.
module gtc_counter #(
    parameter int unsigned HW = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run_i,
    input  logic            ld_lo_i,
    input  logic            ld_hi_i,
    input  logic [HW-1:0]   ld_data_i,
    output logic [2*HW-1:0] count_o
);
    localparam int unsigned CW = 2 * HW;

    // Advance or load the counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_o <= '0;
        end else if (ld_lo_i) begin
            count_o[HW-1:0] <= ld_data_i;
        end else if (ld_hi_i) begin
            count_o[CW-1:HW] <= ld_data_i;
        end else if (run_i) begin
            count_o <= count_o + CW'(1);
        end
    end

    p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !ld_lo_i && !ld_hi_i) |=> (count_o == $past(count_o) + CW'(1)));
    p_count_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !ld_lo_i && !ld_hi_i) |=> $stable(count_o));
    p_load_lo_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ld_lo_i |=> (count_o[HW-1:0] == $past(ld_data_i)) &&
                    (count_o[CW-1:HW] == $past(count_o[CW-1:HW])));
endmodule

// File: rtl/gtc_compare.sv
// Module gtc_compare
// Holds the 2*HW-bit compare value and the HW-bit increment, and flags a
// hit when enabled and equal to the counter. On a hit with auto-increment
// the compare value grows by the increment. A software write to a compare
// half takes priority over that update.
module gtc_compare #(
    parameter int unsigned HW = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [2*HW-1:0] count_i,
    input  logic            cmp_en_i,
    input  logic            auto_inc_i,
    input  logic            ld_lo_i,
    input  logic            ld_hi_i,
    input  logic            ld_inc_i,
    input  logic [HW-1:0]   ld_data_i,
    output logic [2*HW-1:0] cmp_o,
    output logic [HW-1:0]   inc_o,
    output logic            hit_o
);
    localparam int unsigned CW = 2 * HW;

    logic [CW-1:0] cmp_next;

    // Detect equality with the running count.
    always_comb begin
        hit_o    = cmp_en_i && (count_i == cmp_o);
        cmp_next = cmp_o + {{HW{1'b0}}, inc_o};
    end

    // Update the compare value from software or from a periodic hit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_o <= '0;
        end else if (ld_lo_i) begin
            cmp_o[HW-1:0] <= ld_data_i;
        end else if (ld_hi_i) begin
            cmp_o[CW-1:HW] <= ld_data_i;
        end else if (hit_o && auto_inc_i) begin
            cmp_o <= cmp_next;
        end
    end

    // Capture the periodic increment.
    always_ff @(posedge clk) begin
        if (!rst_n)
            inc_o <= '0;
        else if (ld_inc_i)
            inc_o <= ld_data_i;
    end

    p_auto_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_o && auto_inc_i && !ld_lo_i && !ld_hi_i)
        |=> (cmp_o == $past(cmp_o) + {{HW{1'b0}}, $past(inc_o)}));
    p_oneshot_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!auto_inc_i && !ld_lo_i && !ld_hi_i) |=> $stable(cmp_o));
    p_off_no_hit_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !cmp_en_i |-> !hit_o);
endmodule

// File: rtl/gtimer_cmp.sv
// Module gtimer_cmp
// Register front end of the global counter block. It decodes single-cycle
// bus writes into loads and acknowledge pulses, holds the control and
// interrupt enable bits, and returns read data combinationally. Assumes
// DW >= 17 so that the control acknowledge at bit 16 fits.
module gtimer_cmp #(
    parameter int unsigned DW = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bus_wr,
    input  logic [gtc_pkg::OFF_W-1:0] bus_addr,
    input  logic [DW-1:0]           bus_wdata,
    output logic [DW-1:0]           bus_rdata,
    output logic                    irq
);
    import gtc_pkg::*;

    localparam int unsigned CW = 2 * DW;

    ctrl_t           ctrl_q;
    logic            ien_q;
    logic [CW-1:0]   count;
    logic [CW-1:0]   cmp_val;
    logic [DW-1:0]   inc_val;
    logic            hit;
    logic            pend;

    logic wr_cnt_lo, wr_cnt_hi, wr_cnt_ack;
    logic wr_cmp_lo, wr_cmp_hi, wr_cmp_inc;
    logic wr_ctrl, wr_pend, wr_ien, wr_ack;

    logic [CNT_ACK_N-1:0] cnt_ack_set, cnt_ack_clr, cnt_ack;
    logic [GBL_ACK_N-1:0] gbl_ack_set, gbl_ack_clr, gbl_ack;

    // Decode a write strobe into one pulse per register.
    always_comb begin
        wr_cnt_lo  = bus_wr && (bus_addr == OFF_CNT_LO);
        wr_cnt_hi  = bus_wr && (bus_addr == OFF_CNT_HI);
        wr_cnt_ack = bus_wr && (bus_addr == OFF_CNT_ACK);
        wr_cmp_lo  = bus_wr && (bus_addr == OFF_CMP_LO);
        wr_cmp_hi  = bus_wr && (bus_addr == OFF_CMP_HI);
        wr_cmp_inc = bus_wr && (bus_addr == OFF_CMP_INC);
        wr_ctrl    = bus_wr && (bus_addr == OFF_CTRL);
        wr_pend    = bus_wr && (bus_addr == OFF_PEND);
        wr_ien     = bus_wr && (bus_addr == OFF_IEN);
        wr_ack     = bus_wr && (bus_addr == OFF_ACK);
    end

    // Keep the control bits that are implemented.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (wr_ctrl)
            ctrl_q <= '{run:      bus_wdata[CTRL_RUN_BIT],
                        auto_inc: bus_wdata[CTRL_AUTO_BIT],
                        cmp_en:   bus_wdata[CTRL_EN_BIT]};
    end

    // Keep the interrupt enable bit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ien_q <= 1'b0;
        else if (wr_ien)
            ien_q <= bus_wdata[0];
    end

    gtc_counter #(.HW(DW)) u_counter (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (ctrl_q.run),
        .ld_lo_i   (wr_cnt_lo),
        .ld_hi_i   (wr_cnt_hi),
        .ld_data_i (bus_wdata),
        .count_o   (count)
    );

    gtc_compare #(.HW(DW)) u_compare (
        .clk        (clk),
        .rst_n      (rst_n),
        .count_i    (count),
        .cmp_en_i   (ctrl_q.cmp_en),
        .auto_inc_i (ctrl_q.auto_inc),
        .ld_lo_i    (wr_cmp_lo),
        .ld_hi_i    (wr_cmp_hi),
        .ld_inc_i   (wr_cmp_inc),
        .ld_data_i  (bus_wdata),
        .cmp_o      (cmp_val),
        .inc_o      (inc_val),
        .hit_o      (hit)
    );

    // Route acknowledge set and clear pulses to the sticky rows.
    always_comb begin
        cnt_ack_set = {wr_cnt_hi, wr_cnt_lo};
        cnt_ack_clr = wr_cnt_ack ? bus_wdata[CNT_ACK_N-1:0] : '0;
        gbl_ack_set = {wr_ctrl, wr_cmp_inc, wr_cmp_hi, wr_cmp_lo};
        gbl_ack_clr = wr_ack ? {bus_wdata[ACK_CTRL_BIT], bus_wdata[ACK_INC_BIT],
                                bus_wdata[ACK_CMPHI_BIT], bus_wdata[ACK_CMPLO_BIT]}
                             : '0;
    end

    gtc_stickybits #(.N(CNT_ACK_N)) u_cnt_ack (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (cnt_ack_set),
        .clr_i   (cnt_ack_clr),
        .flags_o (cnt_ack)
    );

    gtc_stickybits #(.N(GBL_ACK_N)) u_gbl_ack (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (gbl_ack_set),
        .clr_i   (gbl_ack_clr),
        .flags_o (gbl_ack)
    );

    gtc_stickybits #(.N(1)) u_pend (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (hit),
        .clr_i   (wr_pend && bus_wdata[0]),
        .flags_o (pend)
    );

    // Gate the pending flag by its enable.
    always_comb begin
        irq = pend && ien_q;
    end

    // Return the addressed register, zero for unmapped offsets.
    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            OFF_CNT_LO:  bus_rdata = count[DW-1:0];
            OFF_CNT_HI:  bus_rdata = count[CW-1:DW];
            OFF_CNT_ACK: bus_rdata[CNT_ACK_N-1:0] = cnt_ack;
            OFF_CMP_LO:  bus_rdata = cmp_val[DW-1:0];
            OFF_CMP_HI:  bus_rdata = cmp_val[CW-1:DW];
            OFF_CMP_INC: bus_rdata = inc_val;
            OFF_CTRL: begin
                bus_rdata[CTRL_RUN_BIT]  = ctrl_q.run;
                bus_rdata[CTRL_AUTO_BIT] = ctrl_q.auto_inc;
                bus_rdata[CTRL_EN_BIT]   = ctrl_q.cmp_en;
            end
            OFF_PEND:    bus_rdata[0] = pend;
            OFF_IEN:     bus_rdata[0] = ien_q;
            OFF_ACK: begin
                bus_rdata[ACK_CMPLO_BIT] = gbl_ack[0];
                bus_rdata[ACK_CMPHI_BIT] = gbl_ack[1];
                bus_rdata[ACK_INC_BIT]   = gbl_ack[2];
                bus_rdata[ACK_CTRL_BIT]  = gbl_ack[3];
            end
            default:     bus_rdata = '0;
        endcase
    end

    p_match_pends_r4: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> pend);
    p_irq_masked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ien_q && !wr_ien) |=> !irq);
    p_unmapped_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 12'h180) |=> $stable(ctrl_q) && $stable(ien_q));
endmodule

// File: tb/gtimer_cmp_tb.sv
`timescale 1ns/1ps
module gtimer_cmp_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int n_chk = 0;
    int n_err = 0;

    gtimer_cmp #(.DW(32)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    always #2 clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bwrite(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bread(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic expect_reg(input string tag, input logic [11:0] a, input logic [31:0] exp);
        logic [31:0] v;
        bread(a, v);
        check(tag, v, exp);
    endtask

    task automatic t_reset();
        expect_reg("R1 counter low", 12'h100, 32'h0);
        expect_reg("R1 control", 12'h240, 32'h0);
        expect_reg("R1 ack", 12'h24C, 32'h0);
        check("R1 irq", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_load();
        bwrite(12'h100, 32'h0000_1234);
        bwrite(12'h104, 32'h0000_ABCD);
        expect_reg("R3 low load", 12'h100, 32'h0000_1234);
        expect_reg("R3 high load", 12'h104, 32'h0000_ABCD);
        bwrite(12'h100, 32'h0000_0055);
        expect_reg("R3 high kept", 12'h104, 32'h0000_ABCD);
    endtask

    task automatic t_acks();
        expect_reg("R9 both set", 12'h110, 32'h3);
        bwrite(12'h110, 32'h1);
        expect_reg("R9 bit0 cleared only", 12'h110, 32'h2);
        bwrite(12'h110, 32'h2);
        expect_reg("R9 all cleared", 12'h110, 32'h0);
        bwrite(12'h200, 32'h0);
        expect_reg("R8 cmp lo ack", 12'h24C, 32'h1);
        bwrite(12'h208, 32'h0);
        expect_reg("R8 inc ack", 12'h24C, 32'h5);
        bwrite(12'h240, 32'h0);
        expect_reg("R8 ctrl ack", 12'h24C, 32'h0001_0005);
        bwrite(12'h24C, 32'h4);
        expect_reg("R8 clear bit2 only", 12'h24C, 32'h0001_0001);
        bwrite(12'h24C, 32'hFFFF_FFFF);
        expect_reg("R8 all cleared", 12'h24C, 32'h0);
    endtask

    task automatic t_count();
        bwrite(12'h100, 32'hFFFF_FFFE);
        bwrite(12'h104, 32'h0000_0005);
        bwrite(12'h240, 32'h100);
        repeat (3) @(negedge clk);
        bwrite(12'h240, 32'h0);
        expect_reg("R2 carry high", 12'h104, 32'h6);
        expect_reg("R2 exact ticks low", 12'h100, 32'h3);
        repeat (4) @(negedge clk);
        expect_reg("R2 holds when stopped", 12'h100, 32'h3);
    endtask

    task automatic t_disabled();
        bwrite(12'h244, 32'h1);
        bwrite(12'h100, 32'h0);
        bwrite(12'h104, 32'h0);
        bwrite(12'h200, 32'h5);
        bwrite(12'h204, 32'h0);
        bwrite(12'h240, 32'h100);
        repeat (20) @(negedge clk);
        bwrite(12'h240, 32'h0);
        expect_reg("R11 no pending when disabled", 12'h244, 32'h0);
    endtask

    task automatic t_match();
        bwrite(12'h248, 32'h1);
        bwrite(12'h100, 32'd50);
        bwrite(12'h200, 32'd60);
        bwrite(12'h240, 32'h101);
        check("R4 no irq before match", {31'b0, irq}, 32'h0);
        repeat (20) @(negedge clk);
        check("R5 irq after match", {31'b0, irq}, 32'h1);
        bwrite(12'h240, 32'h0);
        expect_reg("R4 pending set", 12'h244, 32'h1);
        expect_reg("R7 one-shot keeps compare", 12'h200, 32'd60);
        bwrite(12'h248, 32'h0);
        #1 check("R5 irq masked", {31'b0, irq}, 32'h0);
        expect_reg("R5 flag kept when masked", 12'h244, 32'h1);
        bwrite(12'h248, 32'h1);
        #1 check("R5 irq back", {31'b0, irq}, 32'h1);
        bwrite(12'h244, 32'h0);
        expect_reg("R6 write 0 keeps flag", 12'h244, 32'h1);
        bwrite(12'h244, 32'h1);
        expect_reg("R6 write 1 clears flag", 12'h244, 32'h0);
        #1 check("R6 irq drops", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_auto();
        bwrite(12'h100, 32'h0);
        bwrite(12'h200, 32'd10);
        bwrite(12'h208, 32'd7);
        bwrite(12'h240, 32'h103);
        repeat (18) @(negedge clk);
        bwrite(12'h240, 32'h0);
        expect_reg("R2 count at stop", 12'h100, 32'd20);
        expect_reg("R7 two increments", 12'h200, 32'd24);
        expect_reg("R7 high untouched", 12'h204, 32'h0);
        bwrite(12'h244, 32'h1);
        bwrite(12'h100, 32'hFFFF_FFFC);
        bwrite(12'h200, 32'hFFFF_FFFC);
        bwrite(12'h208, 32'd8);
        bwrite(12'h240, 32'h103);
        repeat (1) @(negedge clk);
        bwrite(12'h240, 32'h0);
        expect_reg("R7 carry into high", 12'h204, 32'h1);
        expect_reg("R7 low after carry", 12'h200, 32'h4);
        expect_reg("R2 count low", 12'h100, 32'hFFFF_FFFF);
    endtask

    task automatic t_misc();
        expect_reg("R10 unmapped reads 0", 12'h300, 32'h0);
        bwrite(12'h240, 32'hFFFF_FEFF);
        expect_reg("R10 control keeps bits 1 0", 12'h240, 32'h3);
        bwrite(12'h240, 32'h0);
        bwrite(12'h24C, 32'hFFFF_FFFF);
        bwrite(12'h110, 32'hFFFF_FFFF);
        bwrite(12'h180, 32'hDEAD_BEEF);
        expect_reg("R10 unmapped write reads 0", 12'h180, 32'h0);
        expect_reg("R10 counter untouched", 12'h100, 32'hFFFF_FFFF);
        expect_reg("R10 ack untouched", 12'h24C, 32'h0);
        expect_reg("R10 cnt ack untouched", 12'h110, 32'h0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_load();
        t_acks();
        t_count();
        t_disabled();
        t_match();
        t_auto();
        t_misc();
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule